// File: doc/BRIEF.md
# PRBS7 Link Self-Test Checker

This block sits on the receive side of a serial link, after clock recovery and deserialisation, and runs an at-speed self test of the link. Received 24-bit payloads arrive on a valid/ready stream. While the test enable input is high, each accepted payload is compared against a locally generated pseudo-random sequence. The sequence uses the polynomial x^7 + x^6 + 1. A live status pin shows every errored payload as a short low pulse, so an external counter can measure the payload error rate.

The test window is exactly the time the enable input is held high. When enable drops, the status pin becomes a sticky result. It is high when the whole window was clean and low when any payload was wrong. It keeps this value until a new test starts or the power-down reset is applied. An internal saturating counter of errored payloads can be read once the test has finished. While the test runs, the normal downstream stream is shut off.

Back-pressure rules: outside a test, the block is a plain pass-through. `in_ready` follows `out_ready`, and a payload moves only when both valid and ready are high. During a test the checker consumes every payload it is offered (`in_ready` is high), and `out_valid` is held low whatever `out_ready` does.

Top module: `prbs7_bist_checker`

## Requirements
- R1: After the active-low power-down reset, and before any test, `pass_o` is high and `err_count` is 0.
- R2: While `bist_en` is low, `out_valid` equals `in_valid`, `out_data` equals `in_data`, and `in_ready` equals `out_ready`. While `bist_en` is high, `out_valid` is 0, `out_data` is 0, and `in_ready` is 1.
- R3: A payload is accepted on a rising clock edge where `bist_en` and `in_valid` are both high. The first accepted payload of a test is the seed: its seven least significant bits, with bit 0 the newest, become the generator state. The seed payload is never flagged.
- R4: Every later accepted payload is compared against the next 24 sequence bits. Each bit n equals bit n-6 XOR bit n-7. Bit 23 is the earliest bit in time and bit 0 the latest. A payload that differs in anywhere from 1 to 24 bits is an errored payload.
- R5: During a test, `pass_o` is low only in the clock-high half of the cycle that follows the edge accepting an errored payload. In every other half-cycle of the test it is high.
- R6: Cycles with `in_valid` low neither advance the sequence nor raise a flag.
- R7: On the first edge where `bist_en` is sampled low after a test, the result is latched. From then on `pass_o` is high if no payload in the window was errored, and low otherwise.
- R8: The latched result holds until the next test starts (the first edge with `bist_en` high) or until reset. A new test clears the earlier result and count.
- R9: `err_count` counts the errored payloads of the current or last test. It saturates at 2^CNT_W-1, is cleared when a test starts, and stays frozen after the test ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Payload clock |
| rst_n | input | 1 | Active-low power-down reset, asynchronous |
| bist_en | input | 1 | Test enable; the test window is the time this input is high |
| in_valid | input | 1 | Received payload valid |
| in_ready | output | 1 | Received payload ready |
| in_data | input | 24 | Received payload |
| out_valid | output | 1 | Downstream payload valid, gated off during a test |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 24 | Downstream payload, zero during a test |
| pass_o | output | 1 | Live error pulse during a test, sticky result afterwards |
| err_count | output | 16 | Saturating count of errored payloads |

## Verification
The bench runs four kinds of test window:
- **Clean PRBS stream with idle gaps.** This shows that gaps neither advance the sequence nor flag anything.
- **Stream with a single flipped bit, a fully inverted word and a flipped earliest bit.** This separates the 1-error and 24-error cases and catches a wrong bit order.
- **Back-to-back windows.** These show that the old result is cleared and the seed is taken again.
- **Long all-error run.** This drives the counter into saturation.

Sampling `pass_o` in both halves of the clock separates the half-cycle pulse from a full-cycle level. Pass-through traffic with `out_ready` toggling, before and between windows, checks the gating of the normal stream.

// File: rtl/prbs7_bist_pkg.sv
package prbs7_bist_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } bist_phase_t;
endpackage

// File: rtl/prbs7_gen.sv
module prbs7_gen #(
  parameter int DATA_W = 24,
  parameter int ORDER  = 7,
  parameter int TAP    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              take,
  input  logic [DATA_W-1:0] seed_word,
  output logic [DATA_W-1:0] exp_word,
  output logic              seeded_eff
);
  logic [ORDER-1:0] state;
  logic             seeded;

  // Expand the current state into the next DATA_W sequence bits, earliest at the MSB.
  always_comb begin
    logic [ORDER-1:0] s;
    logic             b;
    s        = state;
    exp_word = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      b           = s[ORDER-1] ^ s[TAP-1];
      exp_word[i] = b;
      s           = {s[ORDER-2:0], b};
    end
  end

  assign seeded_eff = seeded && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= '0;
      seeded <= 1'b0;
    end else if (take && !seeded_eff) begin
      state  <= seed_word[ORDER-1:0];
      seeded <= 1'b1;
    end else if (take) begin
      state  <= exp_word[ORDER-1:0];
    end else if (start) begin
      seeded <= 1'b0;
    end
  end

  // R3: a test start without a payload leaves the generator waiting for a seed
  a_r3_seed_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !take) |=> !seeded);
  // R6: the state moves only on accepted payloads
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !start) |=> $stable(state));
endmodule

// File: rtl/payload_compare.sv
module payload_compare #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              check,
  input  logic [DATA_W-1:0] rx_word,
  input  logic [DATA_W-1:0] exp_word,
  output logic              err_now,
  output logic              err_flag
);
  localparam int CW = $clog2(DATA_W + 1);
  logic [DATA_W-1:0] diff;
  logic [CW-1:0]     nbad;

  assign diff = rx_word ^ exp_word;

  always_comb begin
    nbad = '0;
    for (int i = 0; i < DATA_W; i++) nbad = nbad + CW'(diff[i]);
  end

  assign err_now = check && (nbad != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flag <= 1'b0;
    else        err_flag <= err_now;
  end

  // R5: a flag never survives a cycle without a checked payload
  a_r5_flag_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !check) |=> !err_flag);
  // R4: a flag implies the previous cycle checked a payload
  a_r4_flag_needs_check: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> $past(check));
endmodule

// File: rtl/bist_result.sv
module bist_result
  import prbs7_bist_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bist_en,
  input  logic             err_now,
  input  logic             err_flag,
  output bist_phase_t      phase,
  output logic             start,
  output logic [CNT_W-1:0] err_count,
  output logic             pass_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic sticky;

  assign start = bist_en && (phase != PH_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      sticky    <= 1'b0;
      err_count <= '0;
    end else if (start) begin
      phase     <= PH_RUN;
      sticky    <= 1'b0;
      err_count <= '0;
    end else if (bist_en) begin
      if (err_now) begin
        sticky <= 1'b1;
        if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
      end
    end else if (phase == PH_RUN) begin
      phase <= PH_DONE;
    end
  end

  // Live pulse in the clock-high half during the run, sticky level afterwards.
  always_comb begin
    unique case (phase)
      PH_RUN:  pass_o = ~(err_flag & clk);
      PH_DONE: pass_o = ~sticky;
      default: pass_o = 1'b1;
    endcase
  end

  // R8: a test start clears the count
  a_r8_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (err_count == '0));
  // R9: saturation holds the maximum
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX && !start) |=> (err_count == CNT_MAX));
  // R9: frozen after the window
  a_r9_frozen_after: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE && !bist_en) |=> ($stable(err_count) && $stable(sticky)));
  // R7: an errored payload always marks the result
  a_r7_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    (err_now && !start) |=> sticky);
endmodule

// File: rtl/prbs7_bist_checker.sv
module prbs7_bist_checker
  import prbs7_bist_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bist_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              pass_o,
  output logic [CNT_W-1:0]  err_count
);
  bist_phase_t       phase;
  logic              start, take, seeded_eff, err_now, err_flag;
  logic [DATA_W-1:0] exp_word;

  assign take      = bist_en && in_valid;
  assign in_ready  = bist_en ? 1'b1 : out_ready;
  assign out_valid = in_valid && !bist_en;
  assign out_data  = bist_en ? '0 : in_data;

  prbs7_gen #(.DATA_W(DATA_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .take(take),
    .seed_word(in_data), .exp_word(exp_word), .seeded_eff(seeded_eff)
  );

  payload_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .check(take && seeded_eff),
    .rx_word(in_data), .exp_word(exp_word),
    .err_now(err_now), .err_flag(err_flag)
  );

  bist_result #(.CNT_W(CNT_W)) u_res (
    .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .err_now(err_now),
    .err_flag(err_flag), .phase(phase), .start(start),
    .err_count(err_count), .pass_o(pass_o)
  );

  // R3: the seed payload of a new test is never flagged
  a_r3_no_flag_on_seed: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !err_flag);
  // R2: nothing leaves downstream while the test enable is high
  a_r2_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && bist_en) |-> (!out_valid && in_ready));
endmodule

// File: tb/prbs7_bist_checker_test.sv
module prbs7_bist_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bist_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_data = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, pass_o;
  logic [23:0] out_data;
  logic [15:0] err_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int m_phase = 0; // 0 idle, 1 run, 2 done
  bit m_seeded = 0, m_flag = 0, m_sticky = 0;
  int m_cnt = 0;
  bit m_hist[$];
  bit tx_hist[$];

  always #10 clk = ~clk;

  prbs7_bist_checker uut (
    .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .pass_o(pass_o),
    .err_count(err_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] next_from(ref bit h[$]);
    logic [23:0] w;
    for (int i = 23; i >= 0; i--) begin
      bit b;
      b = h[h.size()-6] ^ h[h.size()-7];
      w[i] = b;
      h.push_back(b);
      h.pop_front();
    end
    return w;
  endfunction

  function automatic void seed_into(ref bit h[$], input logic [23:0] w);
    h.delete();
    for (int i = 6; i >= 0; i--) h.push_back(w[i]);
  endfunction

  // Model update at the edge, checks in the clock-high half.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_phase = 0; m_flag = 0; m_sticky = 0; m_cnt = 0; m_seeded = 0;
    end else if (bist_en) begin
      if (m_phase != 1) begin
        m_phase = 1; m_cnt = 0; m_sticky = 0; m_seeded = 0;
      end
      m_flag = 0;
      if (in_valid) begin
        if (!m_seeded) begin
          seed_into(m_hist, in_data); m_seeded = 1;
        end else if (in_data != next_from(m_hist)) begin
          m_flag = 1; m_sticky = 1;
          if (m_cnt < 65535) m_cnt++;
        end
      end
    end else begin
      m_flag = 0;
      if (m_phase == 1) m_phase = 2;
    end
    #5;
    if (rst_n) begin
      bit ep;
      ep = (m_phase == 1) ? !m_flag : (m_phase == 2) ? !m_sticky : 1'b1;
      check(pass_o == ep, (m_phase == 1) ? "R5" : (m_phase == 2) ? "R7/R8" : "R1",
            "pass_o high phase", pass_o, ep);
      check(err_count == m_cnt[15:0], "R9", "err_count", err_count, m_cnt);
      if (bist_en)
        check(!out_valid && out_data == 0 && in_ready, "R2", "gated outputs",
              {out_valid, in_ready, out_data}, {2'b01, 24'h0});
      else
        check(out_valid == in_valid && out_data == in_data && in_ready == out_ready,
              "R2", "pass-through", {out_valid, in_ready, out_data},
              {in_valid, out_ready, in_data});
    end
  end

  // Low half of the clock: the live pulse must be gone.
  always @(negedge clk) begin
    #5;
    if (rst_n && m_phase == 1 && bist_en)
      check(pass_o == 1'b1, "R5", "pass_o low phase", pass_o, 1);
  end

  always @(posedge clk) begin
    if (cycles > 200000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <200000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic drive(input bit en, input bit v, input logic [23:0] d);
    @(negedge clk);
    bist_en = en; in_valid = v; in_data = d;
  endtask

  task automatic tx_seed(input logic [23:0] w);
    seed_into(tx_hist, w);
    drive(1, 1, w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    #5 check(pass_o == 1'b1 && err_count == 0, "R1", "in reset", {pass_o, err_count}, {1'b1, 16'h0});
    @(negedge clk); rst_n = 1'b1;
    // R2: pass-through with ready toggling
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); out_ready = i[0]; in_valid = i[1]; in_data = 24'h00A5A5 + i;
    end
    // Clean window with gaps (R3, R4, R6, R7)
    tx_seed(24'h5A3C7F);
    for (int i = 0; i < 12; i++) begin
      if (i % 3 == 2) drive(1, 0, 24'hFFFFFF);
      else drive(1, 1, next_from(tx_hist));
    end
    drive(0, 0, 0);
    repeat (4) drive(0, 1, 24'h123456);
    // Errored window: single bit, all bits, earliest bit (R4, R5, R7)
    tx_seed(24'h000041);
    drive(1, 1, next_from(tx_hist));
    drive(1, 1, next_from(tx_hist) ^ 24'h000001);
    drive(1, 1, next_from(tx_hist));
    drive(1, 1, next_from(tx_hist) ^ 24'hFFFFFF);
    drive(1, 0, 0);
    drive(1, 1, next_from(tx_hist) ^ 24'h800000);
    drive(1, 1, next_from(tx_hist));
    drive(0, 0, 0);
    repeat (5) drive(0, 0, 0);
    // New clean window clears the old result (R8), seed with no gap before
    tx_seed(24'h7F7F7F);
    repeat (5) drive(1, 1, next_from(tx_hist));
    drive(0, 1, 24'hABCDEF);
    repeat (3) drive(0, 0, 0);
    // Saturation: zero seed gives an all-zero sequence, send all ones (R9)
    drive(1, 1, 24'h000000);
    for (int i = 0; i < 65540; i++) drive(1, 1, 24'hFFFFFF);
    drive(0, 0, 0);
    repeat (4) drive(0, 0, 0);
    // Power-down reset ends the held result (R8, R1)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #5;
    check(pass_o == 1'b1 && err_count == 0, "R8", "after reset", {pass_o, err_count}, {1'b1, 16'h0});
    @(negedge clk); rst_n = 1'b1;
    repeat (3) drive(0, 0, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule